// File: doc/BRIEF.md
# Piecewise-Linear DAC Code Corrector

This block sits between a sample source and a digital-to-analog converter and cancels the converter's static linearity error. The 16-bit input scale is split into 1024 equal segments of 64 codes. A coefficient table holds 1025 calibrated codes, one for each segment boundary. Entry k is the code that makes the converter produce the ideal output for input code 64·k. For every incoming code the block reads the two boundary entries around it and interpolates linearly between them. The division by the ideal segment span becomes a 6-bit arithmetic right shift.

Each segment uses only its own two end entries, so an error in one segment does not carry into the next. After reset the table holds an identity map, so the block passes codes through unchanged until a board-level calibration writes real coefficients through the write port. Results leave through a two-stage pipeline with valid/ready flow control. An output option converts the result to two's complement for converters that take signed data.

Top module: `pwl_code_corrector`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and table entry k holds 64·k for k below 1024 and 65535 for k = 1024.
- R2: The upper 10 bits of `in_code` give the segment index s. The low entry is table[s] and the high entry is table[s+1], so segment 1023 uses entry 1024.
- R3: The result is low + floor(((high − low) · f) / 64), where f is the low 6 bits of `in_code`. The difference is signed, so segments whose high entry is below their low entry interpolate downward.
- R4: The result always lies between the two entries of its segment. With f = 0 it equals the low entry. It is clamped to 0..65535.
- R5: A write with `coeff_we` = 1 stores `coeff_data` at `coeff_addr` when that address is 0..1024. Writes to addresses 1025..2047 change no entry. A write takes effect for inputs accepted on any later cycle.
- R6: An input is accepted on a rising edge where `in_valid` and `in_ready` are both 1. When `out_ready` stays 1, its result appears with `out_valid` = 1 after the second rising edge counted from the acceptance edge. Back-to-back inputs give one result per cycle, in order.
- R7: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and both `out_valid` and `out_code` hold their values.
- R8: `out_twos` is captured together with the code it is accepted with. When it is 1, bit 15 of that result is inverted, mapping 0..65535 onto two's complement −32768..32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input code present |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_code | input | 16 | Uncorrected code, 0..65535 |
| out_twos | input | 1 | Per-sample request for two's complement output |
| out_valid | output | 1 | Corrected code present |
| out_ready | input | 1 | Downstream accepts the corrected code |
| out_code | output | 16 | Corrected code |
| coeff_we | input | 1 | Coefficient write strobe |
| coeff_addr | input | 11 | Coefficient entry index |
| coeff_data | input | 16 | Coefficient value |

## Verification
A corrected code is due after the second rising edge counted from the edge that accepted its input. The bench stamps each expected item with the cycle in which its input was presented. While the output is never stalled, the monitor checks that the result arrives exactly two cycles after that stamp. Under random output stalls, only order and value are compared, and every stalled cycle is checked for a held output and a low `in_ready`. Coefficient writes complete before the first input that depends on them is presented, and the bench model tracks each write, or ignores it when its address is out of range.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    localparam int CODE_W  = 16;
    localparam int SEG_W   = 10;
    localparam int FRAC_W  = CODE_W - SEG_W;
    localparam int ENTRIES = (1 << SEG_W) + 1;
    localparam int ADDR_W  = SEG_W + 1;
    localparam int DIFF_W  = CODE_W + 1;
    localparam int PROD_W  = DIFF_W + FRAC_W;
    localparam int SUM_W   = CODE_W + 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic              twos;
    } meta_t;

    function automatic code_t ident_coeff(input int k);
        longint v;
        v = longint'(k) << FRAC_W;
        if (v > longint'((1 << CODE_W) - 1))
            v = longint'((1 << CODE_W) - 1);
        return code_t'(v);
    endfunction
endpackage

// File: rtl/pwl_coeff_table.sv
module pwl_coeff_table
    import pwl_pkg::*;
#(
    parameter int N_SEG_W = SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [N_SEG_W:0]  waddr,
    input  code_t             wdata,
    input  logic              rd_en,
    input  logic [N_SEG_W-1:0] seg,
    output code_t             lo_q,
    output code_t             hi_q
);
    localparam int N_ENT = (1 << N_SEG_W) + 1;

    code_t mem [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N_ENT; k++)
                mem[k] <= ident_coeff(k);
        end else if (we && (int'(waddr) < N_ENT)) begin
            mem[waddr] <= wdata;
        end
    end

    logic [N_SEG_W:0] seg_hi;
    assign seg_hi = (N_SEG_W+1)'(seg) + (N_SEG_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (rd_en) begin
            lo_q <= mem[seg];
            hi_q <= mem[seg_hi];
        end
    end
endmodule

// File: rtl/pwl_interp.sv
module pwl_interp
    import pwl_pkg::*;
(
    input  code_t             lo,
    input  code_t             hi,
    input  logic [FRAC_W-1:0] frac,
    output code_t             res
);
    logic signed [DIFF_W-1:0] diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [DIFF_W-1:0] step;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        diff = $signed({1'b0, hi}) - $signed({1'b0, lo});
        prod = PROD_W'(diff) * PROD_W'($signed({1'b0, frac}));
        step = DIFF_W'(prod >>> FRAC_W);
        sum  = SUM_W'($signed({1'b0, lo})) + SUM_W'(step);
        if (sum < 0)
            res = '0;
        else if (sum > SUM_W'((1 << CODE_W) - 1))
            res = '1;
        else
            res = sum[CODE_W-1:0];
    end

    always_comb begin
        if (hi >= lo) begin
            p_bounded_up_r4: assert (res >= lo && res <= hi);
        end else begin
            p_bounded_dn_r4: assert (res <= lo && res >= hi);
        end
        if (frac == '0) begin
            p_endpoint_r4: assert (res == lo);
        end
    end
endmodule

// File: rtl/pwl_code_corrector.sv
module pwl_code_corrector
    import pwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_code,
    input  logic              out_twos,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_code,
    input  logic              coeff_we,
    input  logic [10:0]       coeff_addr,
    input  logic [15:0]       coeff_data
);
    logic  advance;
    logic  s1_valid;
    meta_t s1_meta;
    code_t lo_c, hi_c, interp;

    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;

    pwl_coeff_table #(.N_SEG_W(SEG_W)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (coeff_we),
        .waddr (coeff_addr),
        .wdata (coeff_data),
        .rd_en (advance),
        .seg   (in_code[CODE_W-1 -: SEG_W]),
        .lo_q  (lo_c),
        .hi_q  (hi_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_meta  <= '0;
        end else if (advance) begin
            s1_valid      <= in_valid;
            s1_meta.frac  <= in_code[FRAC_W-1:0];
            s1_meta.twos  <= out_twos;
        end
    end

    pwl_interp u_interp (
        .lo   (lo_c),
        .hi   (hi_c),
        .frac (s1_meta.frac),
        .res  (interp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else if (advance) begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_code <= interp ^ {s1_meta.twos, {(CODE_W-1){1'b0}}};
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && in_ready) |=> out_valid);
endmodule

// File: tb/pwl_code_corrector_test.sv
module pwl_code_corrector_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, out_twos, out_valid, out_ready, coeff_we;
    logic [15:0] in_code, out_code, coeff_data;
    logic [10:0] coeff_addr;

    always #10 clk = ~clk;

    pwl_code_corrector uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .out_twos(out_twos), .out_valid(out_valid),
        .out_ready(out_ready), .out_code(out_code), .coeff_we(coeff_we),
        .coeff_addr(coeff_addr), .coeff_data(coeff_data)
    );

    typedef struct {
        int    exp;
        int    acc;
        string req;
    } item_t;

    item_t q[$];
    int    model [0:1024];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    lat_mode = 1'b0;
    bit    bp_mode  = 1'b0;
    bit    hold_pend = 1'b0;
    int    hold_val = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_code(input int c, input bit t);
        int k, f, d, r;
        k = c >> 6;
        f = c & 63;
        d = model[k+1] - model[k];
        r = model[k] + ((d * f) >>> 6);
        if (r < 0) r = 0;
        if (r > 65535) r = 65535;
        if (t) r = r ^ 32'h8000;
        return r;
    endfunction

    task automatic send(input int c, input bit t, input string req);
        item_t it;
        in_valid = 1'b1;
        in_code  = 16'(c);
        out_twos = t;
        while (!in_ready) @(negedge clk);
        it.exp = ref_code(c, t);
        it.acc = cyc;
        it.req = req;
        q.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        coeff_we   = 1'b1;
        coeff_addr = 11'(a);
        coeff_data = 16'(d);
        @(negedge clk);
        coeff_we = 1'b0;
        if (a <= 1024) model[a] = d;
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R6 unexpected output", int'(out_code), -1);
            end else begin
                item_t it;
                it = q.pop_front();
                check(int'(out_code) == it.exp, it.req, int'(out_code), it.exp);
                if (lat_mode)
                    check(cyc - it.acc == 2, "R6 latency", cyc - it.acc, 2);
            end
        end
    end

    // stall monitor
    always @(negedge clk) begin
        if (hold_pend)
            check(out_valid && int'(out_code) == hold_val, "R7 hold", int'(out_code), hold_val);
        hold_pend = !rst && out_valid && !out_ready;
        hold_val  = int'(out_code);
        if (hold_pend)
            check(!in_ready, "R7 in_ready low", int'(in_ready), 0);
    end

    // random backpressure, changed just after the edge
    always @(posedge clk) begin
        #1;
        if (bp_mode) out_ready = ($urandom_range(0, 2) != 0);
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R6 watchdog", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_code = '0; out_twos = 1'b0;
        out_ready = 1'b1; coeff_we = 1'b0; coeff_addr = '0; coeff_data = '0;
        for (int k = 0; k <= 1024; k++) model[k] = (k == 1024) ? 65535 : k * 64;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R1/R3 identity table, back-to-back with latency checks (R6)
        lat_mode = 1'b1;
        send(0, 0, "R1 identity");
        send(1, 0, "R1 identity");
        send(63, 0, "R1 identity");
        send(64, 0, "R1 identity");
        send(12345, 0, "R1 identity");
        send(32768, 0, "R1 identity");
        send(65471, 0, "R1 identity");
        send(65472, 0, "R2 top segment");
        send(65535, 0, "R2 top segment");
        drain();

        // R3 decreasing and steep segments
        wr(5, 1000);
        wr(6, 900);
        wr(7, 3000);
        send(5*64 + 0, 0, "R3 decreasing f=0");
        send(5*64 + 1, 0, "R3 decreasing f=1");
        send(5*64 + 31, 0, "R3 decreasing f=31");
        send(5*64 + 63, 0, "R3 decreasing f=63");
        send(6*64 + 17, 0, "R3 steep");
        send(4*64 + 40, 0, "R3 into written entry");
        drain();

        // R5 out-of-range writes ignored
        wr(1025, 111);
        wr(2047, 222);
        wr(1030, 333);
        send(1*64 + 10, 0, "R5 ignored write");
        send(0*64 + 3, 0, "R5 ignored write");
        send(6*64 + 2, 0, "R5 ignored write");
        send(1023*64 + 5, 0, "R5 ignored write");
        drain();

        // R2 end-point entry 1024
        wr(1023, 50000);
        wr(1024, 40000);
        send(1023*64 + 0, 0, "R2 last segment");
        send(1023*64 + 32, 0, "R2 last segment");
        send(1023*64 + 63, 0, "R2 last segment");
        send(1022*64 + 63, 0, "R2 neighbour segment");
        drain();

        // R8 two's complement output
        send(0, 1, "R8 twos");
        send(32768, 1, "R8 twos");
        send(65535, 1, "R8 twos");
        send(5*64 + 31, 1, "R8 twos");
        send(1000, 0, "R8 plain after twos");
        drain();

        // R7 random backpressure stream
        lat_mode = 1'b0;
        bp_mode  = 1'b1;
        for (int i = 0; i < 60; i++)
            send((i * 1637 + 77) & 65535, i[0], "R7 stream");
        bp_mode = 1'b0;
        @(posedge clk);
        #1 out_ready = 1'b1;
        drain();
        check(q.size() == 0, "R6 all results delivered", q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule